// File: doc/BRIEF.md
# SDRAM Command Timing Checker

This block is a passive monitor for the command bus of a single data rate SDRAM that has two ranks of four banks each. It watches chip select and clock enable for each rank, the three strobes, the bank address and the auto-precharge bit on every rising clock edge. It never drives the bus. It keeps a small state machine for each bank of each rank, a set of saturating cycle counters, and the rank-wide rules. Any command that breaks an ordering rule or a minimum spacing raises a one-cycle violation pulse. The pulse carries a 3-bit cause code, the rank and the bank.

All spacings are parameters counted in clock cycles, so the same monitor serves any clock period once the nanosecond limits are rounded up to whole cycles. Each bank's state machine has three states. `BK_IDLE` means precharged. `BK_ACTIVE` means a row is open. `BK_AP_BURST` means a column burst with auto-precharge is running. The transitions are named as follows:
- *open*: an activate moves IDLE to ACTIVE.
- *close*: a precharge moves ACTIVE to IDLE.
- *auto-close*: a read or write with the auto-precharge bit set moves ACTIVE to AP_BURST.
- *burst-end*: AP_BURST returns to IDLE `BURST_LEN` cycles after its command.

Top module: `sdram_cmd_checker`

## Requirements
- R1: A rank decodes a command only on an edge where its `cs_n` bit is 0 and its `cke` bit was 1 at the previous edge. Otherwise the cycle is a no-operation that is never flagged and changes no state. Strobe encoding {ras_n,cas_n,we_n} is: 000 mode-register set, 001 refresh, 011 activate, 010 precharge, 101 read, 100 write, 110 burst stop, 111 no-operation.
- R2: A violating command sampled at edge k sets `viol_valid` high for exactly the cycle after edge k. That cycle also carries `viol_code`, `viol_rank` and `viol_bank`. When `viol_valid` is low, all three fields are 0.
- R3: A read or write to an active bank fewer than `T_RCD` cycles after that bank's activate gives code 1.
- R4: An activate to an idle bank gives code 2 if fewer than `T_RP` cycles have passed since the bank was last precharged, or fewer than `T_RC` cycles since its previous activate.
- R5: An activate gives code 3 if it comes fewer than `T_RRD` cycles after the last accepted activate in the same rank.
- R6: A precharge gives code 4 if it reaches an active bank fewer than `T_RAS` cycles after that bank's activate.
- R7: The following give code 5: an activate to a bank that is not idle; a read or write to a bank that is not active; a precharge to a bank in an auto-precharge burst; a mode-register set or refresh while any bank of the rank is not idle. For the last case the lowest non-idle bank is reported.
- R8: Any decoded command other than no-operation gives code 6 if it comes fewer than `T_MRD` cycles after an accepted mode-register set in the same rank.
- R9: While any bank of a rank is in an auto-precharge burst, a read or write to that rank gives code 7. The burst ends `BURST_LEN` cycles after its command. At that point the bank becomes idle and its `T_RP` window starts again.
- R10: Read and write commands on consecutive cycles to open banks are never flagged.
- R11: A precharge with `a10` = 1 addresses every bank of the rank and ignores `ba`. It moves all banks to idle and restarts the `T_RP` window of every bank, including banks that were already idle. Its `T_RAS` check reports the lowest offending bank.
- R12: Causes are ranked 6, then 7, then 5 and the per-bank timing codes, then 3. When ranks clash, the lowest rank wins. A flagged command changes no tracking state.
- R13: After reset, every bank is idle, every spacing window is already satisfied, and outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | NUM_RANKS | Chip select per rank, active low |
| cke | input | NUM_RANKS | Clock enable per rank |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Auto-precharge / precharge-all bit |
| viol_valid | output | 1 | One-cycle violation pulse |
| viol_code | output | 3 | Cause code, 1 to 7 |
| viol_rank | output | RANK_W | Rank of the offending command |
| viol_bank | output | BA_W | Bank of the offending command |

## Verification
The bench probes the exact cycle at which each window opens. A counter that is off by one would flag the first legal command or pass the last illegal one. It checks that an auto-precharge burst locks out reads to other banks. It also checks that the burst restarts the precharge window at its end rather than at its command, so a mistimed burst-end would let a too-early activate through. A precharge-all reaches banks that were already idle and chooses the lowest offending bank, and a wrong implementation would miss the restarted window or report the wrong bank. Rejected commands must leave the bank open. Clock-enable gating and mode-register priority over state errors are checked at the ports, because a wrong decode would show up as a spurious or mis-coded pulse.

// File: rtl/sdram_chk_pkg.sv
package sdram_chk_pkg;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_MRS,
        CMD_REF,
        CMD_ACT,
        CMD_PRE,
        CMD_RD,
        CMD_WR,
        CMD_BST
    } cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE,
        BK_ACTIVE,
        BK_AP_BURST
    } bank_state_e;

    typedef enum logic [2:0] {
        V_NONE    = 3'd0,
        V_TRCD    = 3'd1,
        V_TRP_TRC = 3'd2,
        V_TRRD    = 3'd3,
        V_TRAS    = 3'd4,
        V_STATE   = 3'd5,
        V_MRD     = 3'd6,
        V_APLOCK  = 3'd7
    } viol_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_chk_pkg::*;
(
    input  logic cs_n,
    input  logic cke_q,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    always_comb begin
        cmd = CMD_NOP;
        if (!cs_n && cke_q) begin
            unique case ({ras_n, cas_n, we_n})
                3'b000: cmd = CMD_MRS;
                3'b001: cmd = CMD_REF;
                3'b011: cmd = CMD_ACT;
                3'b010: cmd = CMD_PRE;
                3'b101: cmd = CMD_RD;
                3'b100: cmd = CMD_WR;
                3'b110: cmd = CMD_BST;
                3'b111: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdram_bank_fsm.sv
module sdram_bank_fsm
    import sdram_chk_pkg::*;
#(
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_RC      = 9,
    parameter int T_RAS     = 6,
    parameter int BURST_LEN = 4,
    parameter int CNT_W     = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  cmd_e        cmd,
    input  logic        sel,
    input  logic        a10,
    input  logic        apply,
    output bank_state_e state,
    output viol_e       err
);

    localparam int BL_W = $clog2(BURST_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_SAT = '1;
    localparam logic [CNT_W-1:0] LIM_RCD = CNT_W'(T_RCD);
    localparam logic [CNT_W-1:0] LIM_RP  = CNT_W'(T_RP);
    localparam logic [CNT_W-1:0] LIM_RC  = CNT_W'(T_RC);
    localparam logic [CNT_W-1:0] LIM_RAS = CNT_W'(T_RAS);

    bank_state_e      state_q, state_d;
    logic [CNT_W-1:0] act_cnt, pre_cnt;
    logic [BL_W-1:0]  burst_left;
    logic             go, col_cmd, burst_end;

    assign go        = apply && sel;
    assign col_cmd   = (cmd == CMD_RD) || (cmd == CMD_WR);
    assign burst_end = (state_q == BK_AP_BURST) && (burst_left == BL_W'(1));
    assign state     = state_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BK_IDLE;
        else        state_q <= state_d;
    end

    // next state: open, close, auto-close, burst-end
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BK_IDLE: begin
                if (go && cmd == CMD_ACT) state_d = BK_ACTIVE;
            end
            BK_ACTIVE: begin
                if (go && cmd == CMD_PRE)      state_d = BK_IDLE;
                else if (go && col_cmd && a10) state_d = BK_AP_BURST;
            end
            BK_AP_BURST: begin
                if (burst_end) state_d = BK_IDLE;
            end
            default: state_d = BK_IDLE;
        endcase
    end

    // outputs: per-bank rule check for the command in flight
    always_comb begin
        err = V_NONE;
        if (sel) begin
            unique case (cmd)
                CMD_ACT: begin
                    if (state_q != BK_IDLE)
                        err = V_STATE;
                    else if (pre_cnt < LIM_RP || act_cnt < LIM_RC)
                        err = V_TRP_TRC;
                end
                CMD_RD, CMD_WR: begin
                    if (state_q != BK_ACTIVE)
                        err = V_STATE;
                    else if (act_cnt < LIM_RCD)
                        err = V_TRCD;
                end
                CMD_PRE: begin
                    if (state_q == BK_AP_BURST)
                        err = V_STATE;
                    else if (state_q == BK_ACTIVE && act_cnt < LIM_RAS)
                        err = V_TRAS;
                end
                default: err = V_NONE;
            endcase
        end
    end

    // spacing counters and burst countdown
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_cnt    <= CNT_SAT;
            pre_cnt    <= CNT_SAT;
            burst_left <= '0;
        end else begin
            if (go && cmd == CMD_ACT)   act_cnt <= CNT_W'(1);
            else if (act_cnt != CNT_SAT) act_cnt <= act_cnt + 1'b1;

            if ((go && cmd == CMD_PRE) || burst_end) pre_cnt <= CNT_W'(1);
            else if (pre_cnt != CNT_SAT)             pre_cnt <= pre_cnt + 1'b1;

            if (go && col_cmd && a10)  burst_left <= BL_W'(BURST_LEN);
            else if (burst_left != '0) burst_left <= burst_left - 1'b1;
        end
    end

endmodule

// File: rtl/sdram_rank_mon.sv
module sdram_rank_mon
    import sdram_chk_pkg::*;
#(
    parameter int BA_W      = 2,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_RC      = 9,
    parameter int T_RAS     = 6,
    parameter int T_RRD     = 2,
    parameter int T_MRD     = 2,
    parameter int BURST_LEN = 4,
    parameter int CNT_W     = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n,
    input  logic            cke,
    input  logic            ras_n,
    input  logic            cas_n,
    input  logic            we_n,
    input  logic [BA_W-1:0] ba,
    input  logic            a10,
    output logic            err_valid,
    output viol_e           err_code,
    output logic [BA_W-1:0] err_bank,
    output logic            cke_q_o
);

    localparam int NUM_BANKS = 1 << BA_W;
    localparam logic [CNT_W-1:0] CNT_SAT = '1;
    localparam logic [CNT_W-1:0] LIM_RRD = CNT_W'(T_RRD);
    localparam logic [CNT_W-1:0] LIM_MRD = CNT_W'(T_MRD);

    logic             cke_q;
    cmd_e             cmd;
    logic             apply;
    logic [CNT_W-1:0] rrd_cnt, mrs_cnt;
    bank_state_e      bst  [NUM_BANKS];
    viol_e            berr [NUM_BANKS];
    logic             lock, any_busy, any_perr;
    logic [BA_W-1:0]  busy_bank, perr_bank;
    viol_e            perr_code;
    viol_e            code;
    logic [BA_W-1:0]  code_bank;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cke_q <= 1'b0;
        else        cke_q <= cke;
    end
    assign cke_q_o = cke_q;

    sdram_cmd_decode u_dec (
        .cs_n  (cs_n),
        .cke_q (cke_q),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic sel;
        assign sel = (ba == BA_W'(g)) || (cmd == CMD_PRE && a10);
        sdram_bank_fsm #(
            .T_RCD     (T_RCD),
            .T_RP      (T_RP),
            .T_RC      (T_RC),
            .T_RAS     (T_RAS),
            .BURST_LEN (BURST_LEN),
            .CNT_W     (CNT_W)
        ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .cmd   (cmd),
            .sel   (sel),
            .a10   (a10),
            .apply (apply),
            .state (bst[g]),
            .err   (berr[g])
        );
    end

    // rank-wide scans, lowest bank wins
    always_comb begin
        lock      = 1'b0;
        any_busy  = 1'b0;
        any_perr  = 1'b0;
        busy_bank = '0;
        perr_bank = '0;
        perr_code = V_NONE;
        for (int b = NUM_BANKS - 1; b >= 0; b--) begin
            if (bst[b] == BK_AP_BURST) lock = 1'b1;
            if (bst[b] != BK_IDLE) begin
                any_busy  = 1'b1;
                busy_bank = BA_W'(b);
            end
            if (berr[b] != V_NONE) begin
                any_perr  = 1'b1;
                perr_bank = BA_W'(b);
                perr_code = berr[b];
            end
        end
    end

    // cause selection in priority order
    always_comb begin
        code      = V_NONE;
        code_bank = ba;
        if (cmd != CMD_NOP && mrs_cnt < LIM_MRD) begin
            code = V_MRD;
        end else begin
            unique case (cmd)
                CMD_RD, CMD_WR: begin
                    if (lock) code = V_APLOCK;
                    else      code = berr[ba];
                end
                CMD_ACT: begin
                    if (berr[ba] != V_NONE)  code = berr[ba];
                    else if (rrd_cnt < LIM_RRD) code = V_TRRD;
                end
                CMD_PRE: begin
                    if (a10) begin
                        if (any_perr) begin
                            code      = perr_code;
                            code_bank = perr_bank;
                        end
                    end else begin
                        code = berr[ba];
                    end
                end
                CMD_MRS, CMD_REF: begin
                    if (any_busy) begin
                        code      = V_STATE;
                        code_bank = busy_bank;
                    end
                end
                default: code = V_NONE;
            endcase
        end
    end

    assign apply     = (cmd != CMD_NOP) && (code == V_NONE);
    assign err_valid = (code != V_NONE);
    assign err_code  = code;
    assign err_bank  = code_bank;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rrd_cnt <= CNT_SAT;
            mrs_cnt <= CNT_SAT;
        end else begin
            if (apply && cmd == CMD_ACT) rrd_cnt <= CNT_W'(1);
            else if (rrd_cnt != CNT_SAT) rrd_cnt <= rrd_cnt + 1'b1;

            if (apply && cmd == CMD_MRS) mrs_cnt <= CNT_W'(1);
            else if (mrs_cnt != CNT_SAT) mrs_cnt <= mrs_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sdram_cmd_checker.sv
module sdram_cmd_checker
    import sdram_chk_pkg::*;
#(
    parameter int NUM_RANKS = 2,
    parameter int BA_W      = 2,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_RC      = 9,
    parameter int T_RAS     = 6,
    parameter int T_RRD     = 2,
    parameter int T_MRD     = 2,
    parameter int BURST_LEN = 4,
    localparam int RANK_W   = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_RANKS-1:0] cs_n,
    input  logic [NUM_RANKS-1:0] cke,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic [BA_W-1:0]      ba,
    input  logic                 a10,
    output logic                 viol_valid,
    output logic [2:0]           viol_code,
    output logic [RANK_W-1:0]    viol_rank,
    output logic [BA_W-1:0]      viol_bank
);

    localparam int T_MAX = max2(max2(max2(T_RCD, T_RP), max2(T_RC, T_RAS)),
                                max2(T_RRD, T_MRD));
    localparam int CNT_W = $clog2(T_MAX + 1) + 1;

    logic                 rk_valid [NUM_RANKS];
    viol_e                rk_code  [NUM_RANKS];
    logic [BA_W-1:0]      rk_bank  [NUM_RANKS];
    logic [NUM_RANKS-1:0] cke_q_vec;

    logic              sel_valid;
    logic [2:0]        sel_code;
    logic [RANK_W-1:0] sel_rank;
    logic [BA_W-1:0]   sel_bank;

    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
        sdram_rank_mon #(
            .BA_W      (BA_W),
            .T_RCD     (T_RCD),
            .T_RP      (T_RP),
            .T_RC      (T_RC),
            .T_RAS     (T_RAS),
            .T_RRD     (T_RRD),
            .T_MRD     (T_MRD),
            .BURST_LEN (BURST_LEN),
            .CNT_W     (CNT_W)
        ) u_rank (
            .clk       (clk),
            .rst_n     (rst_n),
            .cs_n      (cs_n[r]),
            .cke       (cke[r]),
            .ras_n     (ras_n),
            .cas_n     (cas_n),
            .we_n      (we_n),
            .ba        (ba),
            .a10       (a10),
            .err_valid (rk_valid[r]),
            .err_code  (rk_code[r]),
            .err_bank  (rk_bank[r]),
            .cke_q_o   (cke_q_vec[r])
        );
    end

    always_comb begin
        sel_valid = 1'b0;
        sel_code  = '0;
        sel_rank  = '0;
        sel_bank  = '0;
        for (int r = NUM_RANKS - 1; r >= 0; r--) begin
            if (rk_valid[r]) begin
                sel_valid = 1'b1;
                sel_code  = rk_code[r];
                sel_rank  = RANK_W'(r);
                sel_bank  = rk_bank[r];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            viol_valid <= 1'b0;
            viol_code  <= '0;
            viol_rank  <= '0;
            viol_bank  <= '0;
        end else begin
            viol_valid <= sel_valid;
            viol_code  <= sel_code;
            viol_rank  <= sel_rank;
            viol_bank  <= sel_bank;
        end
    end

endmodule

// File: rtl/sdram_cmd_checker_sva.sv
module sdram_cmd_checker_sva #(
    parameter int NUM_RANKS = 2,
    parameter int BA_W      = 2,
    parameter int RANK_W    = 1,
    parameter int T_MRD     = 2,
    parameter int BURST_LEN = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_RANKS-1:0] cs_n,
    input logic [NUM_RANKS-1:0] cke_q,
    input logic                 ras_n,
    input logic                 cas_n,
    input logic                 we_n,
    input logic                 a10,
    input logic                 viol_valid,
    input logic [2:0]           viol_code,
    input logic [RANK_W-1:0]    viol_rank,
    input logic [BA_W-1:0]      viol_bank
);

    logic live0, mrs0, any0, rw0, any_cmd;
    assign live0 = !cs_n[0] && cke_q[0];
    assign mrs0  = live0 && ({ras_n, cas_n, we_n} == 3'b000);
    assign any0  = live0 && ({ras_n, cas_n, we_n} != 3'b111);
    assign rw0   = live0 && ras_n && !cas_n;

    always_comb begin
        any_cmd = 1'b0;
        for (int r = 0; r < NUM_RANKS; r++)
            if (!cs_n[r] && cke_q[r] && {ras_n, cas_n, we_n} != 3'b111) any_cmd = 1'b1;
    end

    a_r2_pulse_has_code: assert property (@(posedge clk) disable iff (!rst_n)
        viol_valid |-> viol_code != 3'd0);

    a_r2_quiet_fields_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !viol_valid |-> (viol_code == 3'd0 && viol_rank == '0 && viol_bank == '0));

    a_r1_no_cmd_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !any_cmd |=> !viol_valid);

    if (T_MRD >= 2) begin : g_mrd
        a_r8_mrs_gap: assert property (@(posedge clk) disable iff (!rst_n)
            (any0 && $past(mrs0) && !viol_valid) |=>
                (viol_valid && viol_code == 3'd6 && viol_rank == '0));
    end

    if (BURST_LEN >= 2) begin : g_aplock
        a_r9_ap_lockout: assert property (@(posedge clk) disable iff (!rst_n)
            (rw0 && $past(rw0 && a10) && !viol_valid) |=>
                (viol_valid && viol_code == 3'd7 && viol_rank == '0));
    end

endmodule

bind sdram_cmd_checker sdram_cmd_checker_sva #(
    .NUM_RANKS (NUM_RANKS),
    .BA_W      (BA_W),
    .RANK_W    (RANK_W),
    .T_MRD     (T_MRD),
    .BURST_LEN (BURST_LEN)
) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .cke_q      (cke_q_vec),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .a10        (a10),
    .viol_valid (viol_valid),
    .viol_code  (viol_code),
    .viol_rank  (viol_rank),
    .viol_bank  (viol_bank)
);

// File: tb/tb_sdram_cmd_checker.sv
module tb_sdram_cmd_checker;

    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] C_MRS = 3'b000, C_REF = 3'b001, C_ACT = 3'b011,
                           C_PRE = 3'b010, C_RD  = 3'b101, C_WR  = 3'b100,
                           C_NOP = 3'b111;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] cs_n, cke, ba;
    logic       ras_n, cas_n, we_n, a10;
    logic       viol_valid;
    logic [2:0] viol_code;
    logic [0:0] viol_rank;
    logic [1:0] viol_bank;
    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sdram_cmd_checker dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .cke        (cke),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .we_n       (we_n),
        .ba         (ba),
        .a10        (a10),
        .viol_valid (viol_valid),
        .viol_code  (viol_code),
        .viol_rank  (viol_rank),
        .viol_bank  (viol_bank)
    );

    // drive one bus cycle, then sample the result just after the edge
    task automatic bus(input logic [1:0] csm, input logic [1:0] ck,
                       input logic [2:0] c, input int b, input logic ap);
        @(negedge clk);
        cs_n = csm;
        cke  = ck;
        {ras_n, cas_n, we_n} = c;
        ba   = b[1:0];
        a10  = ap;
        @(posedge clk);
        #1;
    endtask

    task automatic cmd(input int r, input logic [2:0] c, input int b, input logic ap);
        logic [1:0] m;
        m    = 2'b11;
        m[r] = 1'b0;
        bus(m, 2'b11, c, b, ap);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) bus(2'b11, 2'b11, C_NOP, 0, 1'b0);
    endtask

    task automatic expect_v(input string req, input int r, input int code, input int b);
        checks++;
        if (code == 0) begin
            if (viol_valid !== 1'b0 || viol_code !== 3'd0) begin
                errors++;
                $display("FAIL %s: got valid=%0d code=%0d, expected no violation",
                         req, viol_valid, viol_code);
            end
        end else if (viol_valid !== 1'b1 || viol_code !== code[2:0] ||
                     viol_rank !== r[0:0] || viol_bank !== b[1:0]) begin
            errors++;
            $display("FAIL %s: got valid=%0d code=%0d rank=%0d bank=%0d, expected code=%0d rank=%0d bank=%0d",
                     req, viol_valid, viol_code, viol_rank, viol_bank, code, r, b);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cs_n  = 2'b11;
        cke   = 2'b11;
        {ras_n, cas_n, we_n} = C_NOP;
        ba    = 2'b00;
        a10   = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        idle(1);
    endtask

    task automatic t_reset();
        do_reset();
        expect_v("R13 outputs after reset", 0, 0, 0);
        cmd(0, C_ACT, 1, 1'b0);
        expect_v("R13 activate straight after reset", 0, 0, 0);
        cmd(0, C_RD, 2, 1'b0);
        expect_v("R13 bank idle after reset", 0, 5, 2);
    endtask

    task automatic t_gating();
        do_reset();
        bus(2'b11, 2'b10, C_NOP, 0, 1'b0);
        cmd(0, C_ACT, 0, 1'b0);
        expect_v("R1 cke low last cycle ignored", 0, 0, 0);
        cmd(0, C_RD, 0, 1'b0);
        expect_v("R1 ignored activate left bank idle", 0, 5, 0);
        bus(2'b11, 2'b11, C_ACT, 0, 1'b0);
        expect_v("R1 cs high ignored", 0, 0, 0);
        cmd(0, C_WR, 0, 1'b0);
        expect_v("R1 deselected activate left bank idle", 0, 5, 0);
    endtask

    task automatic t_trcd();
        do_reset();
        cmd(0, C_ACT, 0, 1'b0);
        cmd(0, C_RD, 0, 1'b0);
        expect_v("R3 read 1 cycle after activate", 0, 1, 0);
        cmd(0, C_WR, 0, 1'b0);
        expect_v("R3 write 2 cycles after activate", 0, 1, 0);
        cmd(0, C_RD, 0, 1'b0);
        expect_v("R3 read at exact window", 0, 0, 0);
        cmd(0, C_WR, 0, 1'b0);
        expect_v("R10 back-to-back write", 0, 0, 0);
        cmd(0, C_RD, 0, 1'b0);
        expect_v("R10 back-to-back read", 0, 0, 0);
    endtask

    task automatic t_tras_trp();
        do_reset();
        cmd(0, C_ACT, 1, 1'b0);
        idle(4);
        cmd(0, C_PRE, 1, 1'b0);
        expect_v("R6 precharge before row time", 0, 4, 1);
        cmd(0, C_PRE, 1, 1'b0);
        expect_v("R6 precharge at row time", 0, 0, 0);
        cmd(0, C_ACT, 1, 1'b0);
        expect_v("R4 activate 1 cycle after precharge", 0, 2, 1);
        cmd(0, C_ACT, 1, 1'b0);
        expect_v("R4 activate 2 cycles after precharge", 0, 2, 1);
        cmd(0, C_ACT, 1, 1'b0);
        expect_v("R4 activate at precharge window", 0, 0, 0);
    endtask

    task automatic t_trrd();
        do_reset();
        cmd(0, C_ACT, 0, 1'b0);
        cmd(0, C_ACT, 2, 1'b0);
        expect_v("R5 second activate too close", 0, 3, 2);
        cmd(0, C_ACT, 2, 1'b0);
        expect_v("R5 second activate at window", 0, 0, 0);
    endtask

    task automatic t_state();
        do_reset();
        cmd(0, C_ACT, 0, 1'b0);
        cmd(0, C_ACT, 0, 1'b0);
        expect_v("R7 activate to open bank", 0, 5, 0);
        cmd(0, C_REF, 0, 1'b0);
        expect_v("R7 refresh with open bank", 0, 5, 0);
        cmd(0, C_MRS, 3, 1'b0);
        expect_v("R7 mode set with open bank", 0, 5, 0);
        cmd(0, C_WR, 3, 1'b0);
        expect_v("R7 write to idle bank", 0, 5, 3);
    endtask

    task automatic t_mrs();
        do_reset();
        cmd(0, C_MRS, 0, 1'b0);
        expect_v("R8 mode set accepted when idle", 0, 0, 0);
        cmd(0, C_ACT, 1, 1'b0);
        expect_v("R8 command inside mode gap", 0, 6, 1);
        cmd(0, C_ACT, 1, 1'b0);
        expect_v("R8 command after mode gap", 0, 0, 0);
        do_reset();
        cmd(0, C_MRS, 0, 1'b0);
        cmd(0, C_NOP, 0, 1'b0);
        expect_v("R8 no-operation in gap not flagged", 0, 0, 0);
        do_reset();
        cmd(0, C_MRS, 0, 1'b0);
        cmd(0, C_RD, 2, 1'b0);
        expect_v("R12 mode gap outranks state error", 0, 6, 2);
    endtask

    task automatic t_autopre();
        do_reset();
        cmd(0, C_ACT, 0, 1'b0);
        idle(2);
        cmd(0, C_RD, 0, 1'b1);
        expect_v("R9 read with auto-precharge accepted", 0, 0, 0);
        cmd(0, C_WR, 0, 1'b0);
        expect_v("R9 write during lockout", 0, 7, 0);
        cmd(0, C_ACT, 1, 1'b0);
        expect_v("R9 activate other bank during burst", 0, 0, 0);
        cmd(0, C_RD, 1, 1'b0);
        expect_v("R9 read other bank during lockout", 0, 7, 1);
        idle(1);
        cmd(0, C_RD, 1, 1'b0);
        expect_v("R9 read after burst end", 0, 0, 0);
        cmd(0, C_ACT, 0, 1'b0);
        expect_v("R9 reactivate before window from burst end", 0, 2, 0);
        cmd(0, C_ACT, 0, 1'b0);
        expect_v("R9 reactivate at window from burst end", 0, 0, 0);
    endtask

    task automatic t_preall();
        do_reset();
        cmd(0, C_ACT, 0, 1'b0);
        idle(1);
        cmd(0, C_ACT, 2, 1'b0);
        idle(5);
        cmd(0, C_PRE, 1, 1'b1);
        expect_v("R11 precharge-all accepted", 0, 0, 0);
        cmd(0, C_ACT, 3, 1'b0);
        expect_v("R11 idle bank window restarted", 0, 2, 3);
        idle(1);
        cmd(0, C_ACT, 3, 1'b0);
        expect_v("R11 idle bank at restarted window", 0, 0, 0);
        cmd(0, C_REF, 0, 1'b0);
        expect_v("R7 refresh reports lowest open bank", 0, 5, 3);
        do_reset();
        cmd(0, C_ACT, 0, 1'b0);
        idle(1);
        cmd(0, C_ACT, 1, 1'b0);
        idle(4);
        cmd(0, C_PRE, 3, 1'b1);
        expect_v("R11 precharge-all reports lowest offender", 0, 4, 1);
        cmd(0, C_RD, 0, 1'b0);
        expect_v("R12 rejected precharge left bank open", 0, 0, 0);
    endtask

    task automatic t_rank();
        do_reset();
        cmd(1, C_ACT, 2, 1'b0);
        expect_v("R12 rank 1 activate", 1, 0, 0);
        cmd(1, C_RD, 2, 1'b0);
        expect_v("R12 rank 1 reported", 1, 1, 2);
        cmd(0, C_ACT, 2, 1'b0);
        expect_v("R12 rank 0 independent", 0, 0, 0);
    endtask

    initial begin
        t_reset();
        t_gating();
        t_trcd();
        t_tras_trp();
        t_trrd();
        t_state();
        t_mrs();
        t_autopre();
        t_preall();
        t_rank();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule